// File: doc/BRIEF.md
# Serial Receive Word Buffer with Acknowledge-to-Pop Registers

This block takes a synchronous serial bit stream, clocked by its own serial clock and marked by a frame strobe, and turns each 32-bit frame into a word. Finished words cross into the bus clock domain through a toggle handshake. They are then held in a sixteen-word (64-byte) first-in first-out buffer.

Software sees the buffer through three memory-mapped registers. The data register shows the oldest held word. Reading it never removes the word, so a speculative or repeated read is harmless. A word is removed only when software writes 1 to a separate write-only acknowledge register. A status register reports how many words are held, and it carries a sticky flag that records words lost because the buffer was full.

Top module: `srx_ackbuf`

## Requirements
- R1: Serial bits are sampled on the rising serial clock edge, most significant bit first. A sample taken with `ser_frame` high is bit 31 of a new word. The word is complete on the 32nd sample, and a frame strobe that arrives before then discards the partial word and starts over.
- R2: Completed words enter the buffer in arrival order. A read of byte address 0x0 returns the oldest held word, or 0 when the buffer is empty.
- R3: Reads have no effect on state. Any number of reads of address 0x0 return the same word and leave the count unchanged.
- R4: A bus write to address 0x4 with `reg_wdata[0]`=1 removes the oldest word. The new count and the new head word are visible in the cycle after the write.
- R5: A write to address 0x4 with `reg_wdata[0]`=0 changes nothing.
- R6: Address 0x4 is write-only, and a read of it returns 0.
- R7: An acknowledge received while the buffer is empty is ignored, and the count stays at 0.
- R8: A read of address 0x8 returns the status word. Bits [4:0] hold the number of held words (0 to 16), bit 8 holds the overrun flag, and all other bits are 0.
- R9: A word that completes while 16 words are held is discarded, and the overrun flag is set. The flag stays set until software writes to 0x8 with bit 8 = 1; a write with bit 8 = 0 leaves it set.
- R10: After reset the count is 0, the overrun flag is 0, and every address reads 0.
- R11: The buffer holds exactly 16 words, and all 16 are returned intact and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| ser_clk | input | 1 | Serial receive clock |
| ser_data | input | 1 | Serial receive data |
| ser_frame | input | 1 | Frame strobe; high with the first bit of a word |
| reg_addr | input | 4 | Register byte address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |

## Verification
The serial path is driven with word values that have distinctive bit patterns, including all-ones, all-zeros, and words with only the top bit or only the bottom bit set. Errors in bit order and in the bit count show up directly in the data register. One frame is cut short by a new strobe, which shows whether a partial word is discarded or leaks into the buffer. Buffer behaviour is checked on every bus cycle against a queue model while acknowledges are given with bit 0 set and clear, on an empty buffer, on a full buffer and on a 17th word. These cases tell apart a correct pop from a pop triggered by a read, an underflow, and a wrongly cleared overrun flag.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int ADDR_W   = 4;
  localparam int BUS_W    = 32;
  localparam logic [ADDR_W-1:0] ADR_DATA = 4'h0;
  localparam logic [ADDR_W-1:0] ADR_ACK  = 4'h4;
  localparam logic [ADDR_W-1:0] ADR_STAT = 4'h8;
  localparam int STAT_OVR_BIT = 8;

  // acknowledge qualifies only on bit 0 set
  function automatic logic ack_strobe(input logic wr, input logic [ADDR_W-1:0] a,
                                      input logic [BUS_W-1:0] d);
    return wr && (a == ADR_ACK) && d[0];
  endfunction

  function automatic logic ovr_clear(input logic wr, input logic [ADDR_W-1:0] a,
                                     input logic [BUS_W-1:0] d);
    return wr && (a == ADR_STAT) && d[STAT_OVR_BIT];
  endfunction
endpackage

// File: rtl/srx_shift.sv
module srx_shift #(
  parameter int W = 32,
  localparam int CW = $clog2(W + 1)
) (
  input  logic         ser_clk,
  input  logic         rst_n,
  input  logic         ser_data,
  input  logic         ser_frame,
  output logic [W-1:0] word_hold,
  output logic         word_tog
);
  logic [W-1:0]  sh;
  logic [CW-1:0] nbits;
  logic          active;
  logic          word_done;

  assign word_done = active && !ser_frame && (nbits == CW'(W - 1));

  always_ff @(posedge ser_clk or negedge rst_n) begin
    if (!rst_n) begin
      sh        <= '0;
      nbits     <= '0;
      active    <= 1'b0;
      word_hold <= '0;
      word_tog  <= 1'b0;
    end else if (ser_frame) begin
      sh     <= {{(W-1){1'b0}}, ser_data};
      nbits  <= CW'(1);
      active <= 1'b1;
    end else if (active) begin
      sh <= {sh[W-2:0], ser_data};
      if (word_done) begin
        word_hold <= {sh[W-2:0], ser_data};
        word_tog  <= ~word_tog;
        active    <= 1'b0;
        nbits     <= '0;
      end else begin
        nbits <= nbits + CW'(1);
      end
    end
  end

  // R1: a completed word always leaves the shifter idle unless a new frame starts
  p_done_idle_r1: assert property (@(posedge ser_clk) disable iff (!rst_n)
    word_done |=> (!active || $past(ser_frame)) || nbits <= CW'(1));
endmodule

// File: rtl/srx_xfer.sv
module srx_xfer #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tog_in,
  input  logic [W-1:0] word_in,
  output logic         push,
  output logic [W-1:0] push_data
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= tog_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign push      = s2 ^ s3;
  assign push_data = word_in;

  // R2: each crossed word produces a single-cycle push
  p_push_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> !push);
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop_req,
  input  logic             ovr_clr,
  output logic [W-1:0]     head,
  output logic [CNT_W-1:0] count,
  output logic             overrun
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic          full, empty, wr_en, pop_eff, drop;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign wr_en   = push && !full;
  assign drop    = push && full;
  assign pop_eff = pop_req && !empty;
  assign head    = mem[rptr];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      count   <= '0;
      overrun <= 1'b0;
    end else begin
      if (wr_en)   wptr <= ptr_inc(wptr);
      if (pop_eff) rptr <= ptr_inc(rptr);
      case ({wr_en, pop_eff})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
      if (drop)         overrun <= 1'b1;
      else if (ovr_clr) overrun <= 1'b0;
    end
  end

  p_count_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  p_ack_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && empty && !push) |=> (count == '0));
  p_ack_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !empty && !push) |=> (count == $past(count) - CNT_W'(1)));
  p_drop_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> overrun);
  p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ovr_clr) |=> overrun);
  p_head_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pop_req && !empty) |=> $stable(head));
endmodule

// File: rtl/srx_ackbuf.sv
module srx_ackbuf
  import srx_pkg::*;
#(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_frame,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [BUS_W-1:0]  reg_wdata,
  output logic [BUS_W-1:0]  reg_rdata
);
  logic [W-1:0]     word_hold, push_data, head;
  logic             word_tog, push, ack_hit, clr_hit, overrun;
  logic [CNT_W-1:0] count;
  logic [BUS_W-1:0] stat_word;

  srx_shift #(.W(W)) u_shift (
    .ser_clk(ser_clk), .rst_n(rst_n), .ser_data(ser_data), .ser_frame(ser_frame),
    .word_hold(word_hold), .word_tog(word_tog));

  srx_xfer #(.W(W)) u_xfer (
    .clk(clk), .rst_n(rst_n), .tog_in(word_tog), .word_in(word_hold),
    .push(push), .push_data(push_data));

  assign ack_hit = ack_strobe(reg_wr, reg_addr, reg_wdata);
  assign clr_hit = ovr_clear(reg_wr, reg_addr, reg_wdata);

  srx_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
    .pop_req(ack_hit), .ovr_clr(clr_hit), .head(head), .count(count),
    .overrun(overrun));

  always_comb begin
    stat_word = '0;
    stat_word[CNT_W-1:0]   = count;
    stat_word[STAT_OVR_BIT] = overrun;
  end

  always_comb begin
    case (reg_addr)
      ADR_DATA: reg_rdata = (count != '0) ? BUS_W'(head) : '0;
      ADR_STAT: reg_rdata = stat_word;
      default:  reg_rdata = '0;
    endcase
  end

  p_ack_reads_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADR_ACK) |-> (reg_rdata == '0));
  p_ack_zero_noop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADR_ACK && !reg_wdata[0] && !push) |=> $stable(count));
endmodule

// File: tb/srx_ackbuf_tb.sv
`timescale 1ns/1ps
module srx_ackbuf_tb;
  logic clk = 0, ser_clk = 0, rst_n = 0;
  logic ser_data = 0, ser_frame = 0, reg_wr = 0;
  logic [3:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  int total = 0, bad = 0;
  bit cmp_en = 0;
  logic [31:0] q[$];
  bit ovr = 0;

  always #2 clk = ~clk;
  always #8 ser_clk = ~ser_clk;

  srx_ackbuf u_dut (.clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_frame(ser_frame), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] model_read(logic [3:0] a);
    if (a == 4'h0) return (q.size() != 0) ? q[0] : 32'h0;
    if (a == 4'h8) return {23'h0, ovr, 3'h0, 5'(q.size())};
    return 32'h0;
  endfunction

  // per-cycle comparison against the queue model (R2, R6, R8)
  always begin
    @(negedge clk); #1;
    if (cmp_en) check("R2/R6/R8 per-cycle", reg_rdata, model_read(reg_addr));
  end

  task automatic bus_write(logic [3:0] a, logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(posedge clk); #1;
    if (a == 4'h4 && d[0] && q.size() != 0) void'(q.pop_front());
    if (a == 4'h8 && d[8]) ovr = 0;
    @(negedge clk); reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic bus_read(logic [3:0] a, output logic [31:0] v);
    @(negedge clk); reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic send_bits(logic [31:0] w, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge ser_clk);
      ser_frame = (i == 0);
      ser_data  = w[31 - i];
    end
  endtask

  task automatic send_word(logic [31:0] w);
    cmp_en = 0;
    send_bits(w, 32);
    if (q.size() < 16) q.push_back(w); else ovr = 1;
  endtask

  task automatic settle();
    @(negedge ser_clk); ser_frame = 0; ser_data = 0;
    repeat (16) @(posedge clk);
    cmp_en = 1;
  endtask

  initial begin
    repeat (3000000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v, first;
    repeat (4) @(posedge clk);
    rst_n = 1;
    // R10 reset state
    bus_read(4'h0, v); check("R10 data", v, 0);
    bus_read(4'h4, v); check("R10 ack", v, 0);
    bus_read(4'h8, v); check("R10 status", v, 0);
    cmp_en = 1;

    // R1 R2 bit order with distinctive patterns
    send_word(32'h8000_0001); send_word(32'hFFFF_FFFF); send_word(32'h0000_0000);
    settle();
    bus_read(4'h8, v); check("R8 count 3", v, 32'd3);
    bus_read(4'h0, v); check("R1 first word MSB first", v, 32'h8000_0001);
    // R3 repeated reads
    first = v;
    for (int i = 0; i < 6; i++) begin bus_read(4'h0, v); check("R3 repeat read", v, first); end
    bus_read(4'h8, v); check("R3 count kept", v, 32'd3);
    // R5 ack with bit0 clear
    bus_write(4'h4, 32'hFFFF_FFFE);
    bus_read(4'h8, v); check("R5 zero ack", v, 32'd3);
    // R6 ack address reads 0
    bus_read(4'h4, v); check("R6 ack read", v, 0);
    // R4 pop
    bus_write(4'h4, 32'h1);
    bus_read(4'h0, v); check("R4 new head", v, 32'hFFFF_FFFF);
    bus_read(4'h8, v); check("R4 count", v, 32'd2);
    bus_write(4'h4, 1); bus_write(4'h4, 1);
    // R7 ack when empty
    bus_write(4'h4, 1);
    bus_read(4'h8, v); check("R7 no underflow", v, 0);
    bus_read(4'h0, v); check("R2 empty reads 0", v, 0);

    // R1 frame restart drops partial word
    cmp_en = 0;
    send_bits(32'hDEAD_BEEF, 13);
    send_word(32'h1234_5678);
    settle();
    bus_read(4'h8, v); check("R1 restart count", v, 32'd1);
    bus_read(4'h0, v); check("R1 restart word", v, 32'h1234_5678);
    bus_write(4'h4, 1);

    // R11 fill 16, R9 overrun
    for (int i = 0; i < 16; i++) send_word(32'hA500_0000 + 32'(i * 32'h0001_0101));
    send_word(32'h0BAD_0BAD);
    settle();
    bus_read(4'h8, v); check("R9 full and overrun", v, 32'h0000_0110);
    bus_write(4'h8, 32'h0000_00FF);
    bus_read(4'h8, v); check("R9 clear with 0 keeps", v, 32'h0000_0110);
    bus_write(4'h8, 32'h0000_0100);
    bus_read(4'h8, v); check("R9 cleared", v, 32'd16);
    for (int i = 0; i < 16; i++) begin
      bus_read(4'h0, v); check("R11 order", v, 32'hA500_0000 + 32'(i * 32'h0001_0101));
      bus_write(4'h4, 1);
    end
    bus_read(4'h8, v); check("R11 drained", v, 0);

    cmp_en = 0;
    repeat (2) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule